// File: doc/BRIEF.md
# System Control Coprocessor Register File

This block sits beside a 32-bit processor core and holds its system registers: a control word, a translation table base, a fault status word and a fault address. A move into the coprocessor carries a 4-bit register index, a 5-bit operation code and a data word. A move out of it carries the index and the operation code, and the value comes back on the same cycle. Two constant words can only be read: an identification word and a cache description word. Both are set by parameters.

Two indices do not hold any storage. A move into either of them is turned into a one-cycle request to the memory system. Index 5 selects a cache maintenance action, and the operation code picks which one. Index 6 asks for the whole translation lookaside buffer to be invalidated. An access the block cannot place gives a one-cycle error pulse and leaves every register as it was.

Top module: `sysctl_cop`

## Requirements
- R1: While `rstN` is low and after it is released, the four writable registers read as zero and `cacheReq`, `cacheAct`, `lineAddr`, `tlbInvAll` and `accessErr` are all zero.
- R2: A write with operation 0 to index 1, 2, 3 or 4 updates, in that order, the control word, table base, fault status or fault address. A read with operation 0 to the same index returns the new value from the next cycle on.
- R3: A read of index 0 returns the `CPU_ID` parameter for operation 0 and the `CACHE_TYPE` parameter for operation 1.
- R4: A write to index 5 with operation 28, 20, 12, 10 or 14 sets `cacheReq` in the cycle after the write. In that cycle `cacheAct` is one-hot with bit 0, 1, 2, 3 or 4 respectively (invalidate both caches, invalidate instruction cache, invalidate data cache, clean data cache, flush data cache), and `lineAddr` is zero.
- R5: A write to index 5 with operation 13, 11 or 15 sets `cacheReq` in the cycle after the write. `cacheAct` then has bit 5, 6 or 7 set (invalidate, clean, flush one data cache line), and `lineAddr` carries the written data word.
- R6: A write to index 6 with an operation code from 2 to 6 inclusive pulses `tlbInvAll` in the cycle after the write. Any other operation code on index 6 gives no pulse and no error.
- R7: A write to index 5 with an operation code not listed in R4 or R5 produces no cache request and no error.
- R8: A write to index 0 or to an index from 7 to 15, or a write with a nonzero operation to indices 1 to 4, pulses `accessErr` in the following cycle and changes no register.
- R9: A read of an index and operation pair not named in R2 or R3 returns zero and pulses `accessErr` in the following cycle.
- R10: When a read and a write address the same register in one cycle, the read returns the value from before the write.
- R11: Every request and error output is high for exactly one cycle per triggering access. When `cacheReq` is low, `cacheAct` and `lineAddr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Move-into-coprocessor strobe |
| rdEn | input | 1 | Move-out-of-coprocessor strobe |
| regIdx | input | 4 | Register index |
| opCode | input | 5 | Operation code |
| wrData | input | 32 | Write data word |
| rdData | output | 32 | Read data, combinational, zero when `rdEn` is low |
| cacheReq | output | 1 | One-cycle cache maintenance request |
| cacheAct | output | 8 | One-hot cache action code |
| lineAddr | output | 32 | Line address for single-line actions |
| tlbInvAll | output | 1 | One-cycle full TLB invalidate request |
| accessErr | output | 1 | One-cycle unrecognised-access pulse |

## Verification
A read and a write can target the same register in one cycle. That case is driven by raising both strobes with the same index and operation 0. The bench samples `rdData` just before the clock edge and expects the old contents, then expects the written value after the edge. Back-to-back cache writes are also issued on consecutive cycles. They must keep `cacheReq` high for two cycles, each cycle with its own action code, and then drop it.

// File: rtl/sysctl_cop_pkg.sv
package sysctl_cop_pkg;
  localparam int IDX_W    = 4;
  localparam int OP_W     = 5;
  localparam int NUM_REGS = 4;
  localparam int SEL_W    = $clog2(NUM_REGS);
  localparam int ACT_W    = 8;

  localparam logic [IDX_W-1:0] IDX_ID    = 4'd0;
  localparam logic [IDX_W-1:0] IDX_CACHE = 4'd5;
  localparam logic [IDX_W-1:0] IDX_TLB   = 4'd6;

  localparam logic [OP_W-1:0] OP_TLB_LO = 5'd2;
  localparam logic [OP_W-1:0] OP_TLB_HI = 5'd6;

  typedef enum logic [1:0] {
    RD_ZERO,
    RD_ID,
    RD_CTYPE,
    RD_REG
  } rdSel_e;

  typedef struct packed {
    logic [NUM_REGS-1:0] regWr;
    logic                cacheReq;
    logic [ACT_W-1:0]    cacheAct;
    logic                lineOp;
    logic                tlbInv;
    logic                err;
    rdSel_e              rdSel;
    logic [SEL_W-1:0]    rdReg;
  } copStrobes_t;

  // Operation code to one-hot action bit for index 5; returns ACT_W when undefined
  function automatic int cacheActBit(input logic [OP_W-1:0] op);
    case (op)
      5'd28:   return 0;
      5'd20:   return 1;
      5'd12:   return 2;
      5'd10:   return 3;
      5'd14:   return 4;
      5'd13:   return 5;
      5'd11:   return 6;
      5'd15:   return 7;
      default: return ACT_W;
    endcase
  endfunction

  localparam int FIRST_LINE_ACT = 5;
endpackage

// File: rtl/sysctl_cop_ctrl.sv
module sysctl_cop_ctrl
  import sysctl_cop_pkg::*;
(
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [IDX_W-1:0] regIdx,
  input  logic [OP_W-1:0]  opCode,
  output copStrobes_t      strb
);

  logic wrErr;
  logic rdErr;
  int   actBit;

  assign actBit = cacheActBit(opCode);

  // Write decode
  always_comb begin
    strb.regWr    = '0;
    strb.cacheReq = 1'b0;
    strb.cacheAct = '0;
    strb.lineOp   = 1'b0;
    strb.tlbInv   = 1'b0;
    wrErr         = 1'b0;
    if (wrEn) begin
      if (regIdx == IDX_CACHE) begin
        for (int b = 0; b < ACT_W; b++) begin
          if (actBit == b) begin
            strb.cacheReq    = 1'b1;
            strb.cacheAct[b] = 1'b1;
            strb.lineOp      = (b >= FIRST_LINE_ACT);
          end
        end
      end else if (regIdx == IDX_TLB) begin
        strb.tlbInv = (opCode >= OP_TLB_LO) && (opCode <= OP_TLB_HI);
      end else begin
        wrErr = 1'b1;
        for (int i = 0; i < NUM_REGS; i++) begin
          if (regIdx == IDX_W'(i + 1)) begin
            if (opCode == '0) begin
              strb.regWr[i] = 1'b1;
              wrErr         = 1'b0;
            end
          end
        end
      end
    end
  end

  // Read decode
  always_comb begin
    strb.rdSel = RD_ZERO;
    strb.rdReg = '0;
    rdErr      = 1'b0;
    if (rdEn) begin
      rdErr = 1'b1;
      if (regIdx == IDX_ID && opCode == OP_W'(0)) begin
        strb.rdSel = RD_ID;
        rdErr      = 1'b0;
      end else if (regIdx == IDX_ID && opCode == OP_W'(1)) begin
        strb.rdSel = RD_CTYPE;
        rdErr      = 1'b0;
      end else begin
        for (int i = 0; i < NUM_REGS; i++) begin
          if (regIdx == IDX_W'(i + 1) && opCode == '0) begin
            strb.rdSel = RD_REG;
            strb.rdReg = SEL_W'(i);
            rdErr      = 1'b0;
          end
        end
      end
    end
  end

  assign strb.err = wrErr | rdErr;

endmodule

// File: rtl/sysctl_cop_dp.sv
module sysctl_cop_dp
  import sysctl_cop_pkg::*;
#(
  parameter int                DATA_W     = 32,
  parameter logic [DATA_W-1:0] CPU_ID     = 32'h4D_01_0863,
  parameter logic [DATA_W-1:0] CACHE_TYPE = 32'h0D_15_2112
) (
  input  logic              clk,
  input  logic              rstN,
  input  copStrobes_t       strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              cacheReq,
  output logic [ACT_W-1:0]  cacheAct,
  output logic [DATA_W-1:0] lineAddr,
  output logic              tlbInvAll,
  output logic              accessErr
);

  logic [DATA_W-1:0] regQ [NUM_REGS];

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : gen_reg
      always_ff @(posedge clk) begin
        if (!rstN)              regQ[g] <= '0;
        else if (strb.regWr[g]) regQ[g] <= wrData;
      end
    end
  endgenerate

  always_comb begin
    case (strb.rdSel)
      RD_ID:    rdData = CPU_ID;
      RD_CTYPE: rdData = CACHE_TYPE;
      RD_REG:   rdData = regQ[strb.rdReg];
      default:  rdData = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cacheReq  <= 1'b0;
      cacheAct  <= '0;
      lineAddr  <= '0;
      tlbInvAll <= 1'b0;
      accessErr <= 1'b0;
    end else begin
      cacheReq  <= strb.cacheReq;
      cacheAct  <= strb.cacheAct;
      lineAddr  <= strb.lineOp ? wrData : '0;
      tlbInvAll <= strb.tlbInv;
      accessErr <= strb.err;
    end
  end

endmodule

// File: rtl/sysctl_cop.sv
module sysctl_cop
  import sysctl_cop_pkg::*;
#(
  parameter int                DATA_W     = 32,
  parameter logic [DATA_W-1:0] CPU_ID     = 32'h4D_01_0863,
  parameter logic [DATA_W-1:0] CACHE_TYPE = 32'h0D_15_2112
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [IDX_W-1:0]  regIdx,
  input  logic [OP_W-1:0]   opCode,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              cacheReq,
  output logic [ACT_W-1:0]  cacheAct,
  output logic [DATA_W-1:0] lineAddr,
  output logic              tlbInvAll,
  output logic              accessErr
);

  copStrobes_t strb;

  sysctl_cop_ctrl u_ctrl (
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .regIdx (regIdx),
    .opCode (opCode),
    .strb   (strb)
  );

  sysctl_cop_dp #(
    .DATA_W     (DATA_W),
    .CPU_ID     (CPU_ID),
    .CACHE_TYPE (CACHE_TYPE)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (wrData),
    .rdData    (rdData),
    .cacheReq  (cacheReq),
    .cacheAct  (cacheAct),
    .lineAddr  (lineAddr),
    .tlbInvAll (tlbInvAll),
    .accessErr (accessErr)
  );

endmodule

// File: rtl/sysctl_cop_chk.sv
module sysctl_cop_chk
  import sysctl_cop_pkg::*;
#(
  parameter int                DATA_W     = 32,
  parameter logic [DATA_W-1:0] CPU_ID     = '0,
  parameter logic [DATA_W-1:0] CACHE_TYPE = '0
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [IDX_W-1:0]  regIdx,
  input logic [OP_W-1:0]   opCode,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic              cacheReq,
  input logic [ACT_W-1:0]  cacheAct,
  input logic [DATA_W-1:0] lineAddr,
  input logic              tlbInvAll,
  input logic              accessErr
);

  assert_cache_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
    cacheReq |-> $past(wrEn && regIdx == IDX_CACHE));

  assert_act_onehot_R5: assert property (@(posedge clk) disable iff (!rstN)
    cacheReq |-> $onehot(cacheAct));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !cacheReq |-> (cacheAct == '0 && lineAddr == '0));

  assert_tlb_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    tlbInvAll |-> $past(wrEn && regIdx == IDX_TLB && opCode >= OP_TLB_LO && opCode <= OP_TLB_HI));

  assert_idx0_write_err_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regIdx == IDX_ID) |=> accessErr);

  assert_undef_read_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && regIdx >= IDX_CACHE) |-> rdData == '0);

  assert_id_read_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && regIdx == IDX_ID && opCode == '0) |-> rdData == CPU_ID);

endmodule

bind sysctl_cop sysctl_cop_chk #(
  .DATA_W     (DATA_W),
  .CPU_ID     (CPU_ID),
  .CACHE_TYPE (CACHE_TYPE)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .rdEn      (rdEn),
  .regIdx    (regIdx),
  .opCode    (opCode),
  .wrData    (wrData),
  .rdData    (rdData),
  .cacheReq  (cacheReq),
  .cacheAct  (cacheAct),
  .lineAddr  (lineAddr),
  .tlbInvAll (tlbInvAll),
  .accessErr (accessErr)
);

// File: tb/sysctl_cop_bench.sv
module sysctl_cop_bench;
  localparam logic [31:0] ID_W = 32'hA5C3_0017;
  localparam logic [31:0] CT_W = 32'h1234_ABCD;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [3:0]  regIdx = '0;
  logic [4:0]  opCode = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        cacheReq;
  logic [7:0]  cacheAct;
  logic [31:0] lineAddr;
  logic        tlbInvAll;
  logic        accessErr;

  int testCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sysctl_cop #(.DATA_W(32), .CPU_ID(ID_W), .CACHE_TYPE(CT_W)) u_sysctl_cop (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .regIdx(regIdx),
    .opCode(opCode), .wrData(wrData), .rdData(rdData), .cacheReq(cacheReq),
    .cacheAct(cacheAct), .lineAddr(lineAddr), .tlbInvAll(tlbInvAll),
    .accessErr(accessErr)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Write, then leave time just after the edge that registers the pulses
  task automatic issueWrite(input logic [3:0] idx, input logic [4:0] op, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; regIdx = idx; opCode = op; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic readBack(input logic [3:0] idx, input logic [4:0] op,
                          output logic [31:0] v, output logic e);
    @(negedge clk);
    rdEn = 1'b1; regIdx = idx; opCode = op;
    #1 v = rdData;
    @(posedge clk); #1;
    e = accessErr;
    rdEn = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] v; logic e;
    check(cacheReq == 0 && tlbInvAll == 0 && accessErr == 0 && cacheAct == 0 && lineAddr == 0,
          "R1 pulses idle", {cacheReq, tlbInvAll, accessErr}, 0);
    for (int i = 1; i <= 4; i++) begin
      readBack(4'(i), 5'd0, v, e);
      check(v == 0, "R1 reg cleared", v, 0);
    end
  endtask

  task automatic testRegWrite();
    logic [31:0] v; logic e;
    for (int i = 1; i <= 4; i++) issueWrite(4'(i), 5'd0, 32'h1111_0000 * i + 32'(i));
    for (int i = 1; i <= 4; i++) begin
      readBack(4'(i), 5'd0, v, e);
      check(v == 32'h1111_0000 * i + 32'(i) && !e, "R2 reg readback", v, 32'h1111_0000 * i + 32'(i));
    end
  endtask

  task automatic testIdRead();
    logic [31:0] v; logic e;
    readBack(4'd0, 5'd0, v, e);
    check(v == ID_W && !e, "R3 id word", v, ID_W);
    readBack(4'd0, 5'd1, v, e);
    check(v == CT_W && !e, "R3 cache type word", v, CT_W);
  endtask

  task automatic testCacheOps();
    logic [4:0] ops [8] = '{5'd28, 5'd20, 5'd12, 5'd10, 5'd14, 5'd13, 5'd11, 5'd15};
    for (int k = 0; k < 8; k++) begin
      logic [31:0] d = 32'hC0DE_0000 + 32'(k * 64);
      logic [31:0] expAddr = (k >= 5) ? d : 32'h0;
      issueWrite(4'd5, ops[k], d);
      if (k < 5) begin
        check(cacheReq && cacheAct == 8'(1 << k) && lineAddr == 0 && !accessErr,
              "R4 whole-cache action", {23'd0, cacheReq, cacheAct}, {23'd0, 1'b1, 8'(1 << k)});
      end else begin
        check(cacheReq && cacheAct == 8'(1 << k) && !accessErr,
              "R5 line action code", {23'd0, cacheReq, cacheAct}, {23'd0, 1'b1, 8'(1 << k)});
        check(lineAddr == expAddr, "R5 line address", lineAddr, expAddr);
      end
      @(posedge clk); #1;
      check(!cacheReq && cacheAct == 0 && lineAddr == 0, "R11 cache pulse one cycle",
            {23'd0, cacheReq, cacheAct}, 0);
    end
  endtask

  task automatic testTlb();
    logic [4:0] badOps [4] = '{5'd0, 5'd1, 5'd7, 5'd31};
    for (int op = 2; op <= 6; op++) begin
      issueWrite(4'd6, 5'(op), 32'h0);
      check(tlbInvAll && !accessErr, "R6 tlb invalidate", {31'd0, tlbInvAll}, 1);
      @(posedge clk); #1;
      check(!tlbInvAll, "R11 tlb pulse one cycle", {31'd0, tlbInvAll}, 0);
    end
    for (int k = 0; k < 4; k++) begin
      issueWrite(4'd6, badOps[k], 32'h0);
      check(!tlbInvAll && !accessErr, "R6 tlb other op ignored", {tlbInvAll, accessErr}, 0);
    end
  endtask

  task automatic testIgnoredCache();
    logic [4:0] ops [4] = '{5'd0, 5'd1, 5'd9, 5'd31};
    for (int k = 0; k < 4; k++) begin
      issueWrite(4'd5, ops[k], 32'hFFFF_FFFF);
      check(!cacheReq && !accessErr && lineAddr == 0, "R7 undefined cache op silent",
            {cacheReq, accessErr}, 0);
    end
  endtask

  task automatic testUnrecWrite();
    logic [31:0] v; logic e;
    logic [3:0] idxs [4] = '{4'd0, 4'd7, 4'd15, 4'd2};
    logic [4:0] ops  [4] = '{5'd0, 5'd0, 5'd0, 5'd3};
    issueWrite(4'd2, 5'd0, 32'h5A5A_5A5A);
    for (int k = 0; k < 4; k++) begin
      issueWrite(idxs[k], ops[k], 32'hDEAD_BEEF);
      check(accessErr && !cacheReq && !tlbInvAll, "R8 unrecognised write error", {31'd0, accessErr}, 1);
      @(posedge clk); #1;
      check(!accessErr, "R11 error pulse one cycle", {31'd0, accessErr}, 0);
    end
    readBack(4'd2, 5'd0, v, e);
    check(v == 32'h5A5A_5A5A, "R8 register unchanged", v, 32'h5A5A_5A5A);
    readBack(4'd0, 5'd0, v, e);
    check(v == ID_W, "R8 id word unchanged", v, ID_W);
  endtask

  task automatic testUndefRead();
    logic [31:0] v; logic e;
    logic [3:0] idxs [5] = '{4'd0, 4'd3, 4'd5, 4'd6, 4'd9};
    logic [4:0] ops  [5] = '{5'd2, 5'd1, 5'd0, 5'd3, 5'd0};
    for (int k = 0; k < 5; k++) begin
      readBack(idxs[k], ops[k], v, e);
      check(v == 0, "R9 undefined read zero", v, 0);
      check(e, "R9 undefined read error", {31'd0, e}, 1);
    end
  endtask

  task automatic testSameCycle();
    logic [31:0] v; logic e;
    issueWrite(4'd3, 5'd0, 32'h0000_AAAA);
    @(negedge clk);
    wrEn = 1'b1; rdEn = 1'b1; regIdx = 4'd3; opCode = 5'd0; wrData = 32'h0000_BBBB;
    #1;
    check(rdData == 32'h0000_AAAA, "R10 same-cycle read old value", rdData, 32'h0000_AAAA);
    @(posedge clk); #1;
    wrEn = 1'b0;
    check(rdData == 32'h0000_BBBB, "R10 value after edge", rdData, 32'h0000_BBBB);
    rdEn = 1'b0;
    readBack(4'd3, 5'd0, v, e);
    check(v == 32'h0000_BBBB, "R2 readback after collision", v, 32'h0000_BBBB);
  endtask

  task automatic testBackToBack();
    @(negedge clk);
    wrEn = 1'b1; regIdx = 4'd5; opCode = 5'd28; wrData = 32'h0;
    @(negedge clk);
    opCode = 5'd13; wrData = 32'h0000_4440;
    #3;
    check(cacheReq && cacheAct == 8'h01, "R11 first back-to-back request", {24'd0, cacheAct}, 32'h01);
    @(posedge clk); #1;
    wrEn = 1'b0;
    check(cacheReq && cacheAct == 8'h20 && lineAddr == 32'h0000_4440,
          "R11 second back-to-back request", {24'd0, cacheAct}, 32'h20);
    @(posedge clk); #1;
    check(!cacheReq, "R11 request drops after pair", {31'd0, cacheReq}, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(cacheReq == 0 && accessErr == 0 && tlbInvAll == 0, "R1 outputs in reset",
          {cacheReq, accessErr, tlbInvAll}, 0);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testRegWrite();
    testIdRead();
    testCacheOps();
    testTlb();
    testIgnoredCache();
    testUnrecWrite();
    testUndefRead();
    testSameCycle();
    testBackToBack();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      testCnt++;
      failCnt++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

endmodule